// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-side cache that holds eight 32-bit words. The words sit in four sets, and each set has two ways. The cache takes 32-bit byte addresses. Each way entry keeps its own valid flag, its own address tag and one data word. A request reads both ways of the addressed set together. If a valid way has a matching tag, a multiplexer returns that way's word one clock after the request.

On a miss the block raises a one-cycle miss pulse. It then stays busy until the requester supplies the missing word on the fill port. The fill is written into an empty way of the set if one exists. Otherwise it goes into the way that was used less recently. Each set tracks this with a single recency bit. A synchronous flush empties the whole cache in one cycle.

Top module: `cache2w_lookup`

## Requirements
- R1: Address bits [1:0] are the byte offset. Bits [3:2] pick the set. Bits [31:4] form the tag. A lookup hits only when the addressed set holds a valid way whose tag equals the address tag.
- R2: While and after a synchronous active-high reset, no way is valid, every recency bit is 0, `busy` is 0 and all response outputs are 0.
- R3: A request taken while idle (`busy`=0, `flush`=0) gives, exactly one clock later, either `rsp_valid`=1 with `rsp_hit`=1, or `rsp_miss`=1. Each of these is a one-cycle pulse.
- R4: On a hit, `rsp_data` is the word stored in the way that matched.
- R5: The two ways of one set never hit at the same time.
- R6: After a miss, `busy` stays 1 and no response appears until `fill_valid` is seen. That cycle writes `fill_data` with the missed tag into the chosen way. One clock later `rsp_valid`=1, `rsp_hit`=0, `rsp_data`=`fill_data` and `busy`=0. Requests made while busy are ignored.
- R7: The fill goes to way 0 if way 0 of the set is invalid. Otherwise it goes to way 1 if way 1 is invalid. If both ways are valid, it goes to the less recently used way: way 1 when the recency bit is 1, way 0 when it is 0.
- R8: The recency bit of a set becomes 1 when way 0 is hit or filled, and 0 when way 1 is hit or filled.
- R9: `flush` clears every valid bit and recency bit in one cycle. It drops a pending miss without a response, and a request in the same cycle is ignored.
- R10: Addresses 0x4 and 0x24 share set 1 and can be held together. Alternating between them gives two misses and then only hits.
- R11: The byte-offset bits do not take part in the lookup. 0x7 hits the entry filled for 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and drop any pending miss |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Byte address of the lookup |
| fill_valid | input | 1 | Fill word present for the pending miss |
| fill_data | input | 32 | Word to be written on a fill |
| busy | output | 1 | A miss is waiting for its fill |
| rsp_valid | output | 1 | Data returned (hit or completed fill) |
| rsp_hit | output | 1 | The returned data came from a hit |
| rsp_miss | output | 1 | The lookup missed |
| rsp_data | output | 32 | Returned word |

## Verification
The hardest case to reach is eviction driven by recency. Both ways of one set must be valid, and the recency bit must have been steered by a known order of hits and fills. Only then can the bench tell whether the wrong way was replaced. The stimulus fills set 1 with two tags, then hits one of them to flip the recency bit. It then misses on a third tag in the same set and checks which older address still hits. It also reaches the rare control cases: a request made while busy, and a flush that lands on a pending miss. The bench then checks that no stale entry or response survives.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctrl_st_e;
  localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int unsigned SETS   = 4,
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst || flush_i) valid_q <= '0;
    else if (wr_en_i)   valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q[rd_idx_i];
  assign hit_o   = valid_o && (tag_mem[rd_idx_i] == rd_tag_i);
  assign data_o  = data_mem[rd_idx_i];

  // R9: a flush empties every set of this way
  a_r9_flush_clears_valid: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (valid_q == '0));
  // R2: nothing valid straight after reset
  a_r2_reset_empty: assert property (@(posedge clk)
    rst |=> (valid_q == '0));
endmodule

// File: rtl/cache2w_victim.sv
module cache2w_victim #(
  parameter int unsigned SETS = 4,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             valid0_i,
  input  logic             valid1_i,
  input  logic             upd_en_i,
  input  logic             upd_way_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic             victim_o
);
  // bit = 1: way 0 touched most recently; bit = 0: way 1
  logic [SETS-1:0] recent_q;

  always_ff @(posedge clk) begin
    if (rst || flush_i) recent_q <= '0;
    else if (upd_en_i)  recent_q[upd_idx_i] <= ~upd_way_i;
  end

  always_comb begin
    if (!valid0_i)      victim_o = 1'b0;
    else if (!valid1_i) victim_o = 1'b1;
    else                victim_o = recent_q[idx_i];
  end

  // R8: polarity of the recency bit after a hit or fill
  a_r8_recency_polarity: assert property (@(posedge clk) disable iff (rst)
    (upd_en_i && !flush_i) |=> (recent_q[$past(upd_idx_i)] == !$past(upd_way_i)));
  // R9: flush clears recency state
  a_r9_flush_clears_recency: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (recent_q == '0));
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int unsigned SETS   = 4,
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_i,
  input  logic                req_valid_i,
  input  logic [IDX_W-1:0]    req_idx_i,
  input  logic [TAG_W-1:0]    req_tag_i,
  input  logic                fill_valid_i,
  input  logic [DATA_W-1:0]   fill_data_i,
  input  logic [NUM_WAYS-1:0] hit_i,
  input  logic [DATA_W-1:0]   hit_data_i,
  input  logic                victim_i,
  output logic                wr_en_o,
  output logic                wr_way_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [TAG_W-1:0]    wr_tag_o,
  output logic                upd_en_o,
  output logic                upd_way_o,
  output logic [IDX_W-1:0]    upd_idx_o,
  output logic                busy_o,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic                rsp_miss_o,
  output logic [DATA_W-1:0]   rsp_data_o
);
  ctrl_st_e         state_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             pend_way_q;
  logic             accept, hit_any, fill;

  assign accept  = (state_q == ST_IDLE) && req_valid_i && !flush_i;
  assign hit_any = |hit_i;
  assign fill    = (state_q == ST_WAIT) && fill_valid_i && !flush_i;

  assign wr_en_o   = fill;
  assign wr_way_o  = pend_way_q;
  assign wr_idx_o  = pend_idx_q;
  assign wr_tag_o  = pend_tag_q;
  assign upd_en_o  = (accept && hit_any) || fill;
  assign upd_way_o = fill ? pend_way_q : hit_i[1];
  assign upd_idx_o = fill ? pend_idx_q : req_idx_i;
  assign busy_o    = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pend_idx_q  <= '0;
      pend_tag_q  <= '0;
      pend_way_q  <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      if (flush_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (req_valid_i) begin
            if (hit_any) begin
              rsp_valid_o <= 1'b1;
              rsp_hit_o   <= 1'b1;
              rsp_data_o  <= hit_data_i;
            end else begin
              rsp_miss_o <= 1'b1;
              pend_idx_q <= req_idx_i;
              pend_tag_q <= req_tag_i;
              pend_way_q <= victim_i;
              state_q    <= ST_WAIT;
            end
          end
          ST_WAIT: if (fill_valid_i) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= fill_data_i;
            state_q     <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: an accepted request is answered by exactly one of hit or miss
  a_r3_answer_next_cycle: assert property (@(posedge clk) disable iff (rst)
    accept |=> (rsp_hit_o ^ rsp_miss_o));
  // R6: nothing is returned while a fill is outstanding
  a_r6_silent_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !fill_valid_i) |=> !rsp_valid_o);
  // R6: a fill completes the miss as a non-hit response
  a_r6_fill_returns: assert property (@(posedge clk) disable iff (rst)
    fill |=> (rsp_valid_o && !rsp_hit_o && !busy_o));
endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup
  import cache2w_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 4,
  localparam int unsigned OFF_W = $clog2(DATA_W / 8),
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_data
);
  logic [IDX_W-1:0]    req_idx;
  logic [TAG_W-1:0]    req_tag;
  logic [NUM_WAYS-1:0] way_hit, way_valid, way_wr;
  logic [DATA_W-1:0]   way_data [NUM_WAYS];
  logic [DATA_W-1:0]   hit_data;
  logic                wr_en, wr_way, upd_en, upd_way, victim;
  logic [IDX_W-1:0]    wr_idx, upd_idx;
  logic [TAG_W-1:0]    wr_tag;

  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign hit_data = way_hit[1] ? way_data[1] : way_data[0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_wr[w] = wr_en && (wr_way == w[0]);
    cache2w_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk       (clk),
      .rst       (rst),
      .flush_i   (flush),
      .rd_idx_i  (req_idx),
      .rd_tag_i  (req_tag),
      .wr_en_i   (way_wr[w]),
      .wr_idx_i  (wr_idx),
      .wr_tag_i  (wr_tag),
      .wr_data_i (fill_data),
      .hit_o     (way_hit[w]),
      .valid_o   (way_valid[w]),
      .data_o    (way_data[w])
    );
  end

  cache2w_victim #(.SETS(SETS)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .flush_i   (flush),
    .idx_i     (req_idx),
    .valid0_i  (way_valid[0]),
    .valid1_i  (way_valid[1]),
    .upd_en_i  (upd_en),
    .upd_way_i (upd_way),
    .upd_idx_i (upd_idx),
    .victim_o  (victim)
  );

  cache2w_ctrl #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush),
    .req_valid_i  (req_valid),
    .req_idx_i    (req_idx),
    .req_tag_i    (req_tag),
    .fill_valid_i (fill_valid),
    .fill_data_i  (fill_data),
    .hit_i        (way_hit),
    .hit_data_i   (hit_data),
    .victim_i     (victim),
    .wr_en_o      (wr_en),
    .wr_way_o     (wr_way),
    .wr_idx_o     (wr_idx),
    .wr_tag_o     (wr_tag),
    .upd_en_o     (upd_en),
    .upd_way_o    (upd_way),
    .upd_idx_o    (upd_idx),
    .busy_o       (busy),
    .rsp_valid_o  (rsp_valid),
    .rsp_hit_o    (rsp_hit),
    .rsp_miss_o   (rsp_miss),
    .rsp_data_o   (rsp_data)
  );

  // R5: the two ways of a set never match together
  a_r5_single_way_hit: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !(way_hit[0] && way_hit[1]));
  // R4: a hit response is always a data response
  a_r4_hit_has_data: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_valid && !rsp_miss));
endmodule

// File: tb/cache2w_lookup_tb.sv
module cache2w_lookup_tb;
  logic        clk = 1'b0;
  logic        rst, flush, req_valid, fill_valid;
  logic [31:0] req_addr, fill_data;
  logic        busy, rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  bit          m_valid [2][4];
  int unsigned m_tag   [2][4];
  int unsigned m_data  [2][4];
  bit          m_recent[4];

  always #10 clk = ~clk;

  cache2w_lookup u_dut (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input bit v, input bit h, input bit m, input bit b);
    check(rsp_valid == v, {req, " rsp_valid"}, 32'(rsp_valid), 32'(v));
    check(rsp_hit   == h, {req, " rsp_hit"},   32'(rsp_hit),   32'(h));
    check(rsp_miss  == m, {req, " rsp_miss"},  32'(rsp_miss),  32'(m));
    check(busy      == b, {req, " busy"},      32'(busy),      32'(b));
  endtask

  task automatic model_clear();
    for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++) m_valid[w][s] = 1'b0;
    for (int s = 0; s < 4; s++) m_recent[s] = 1'b0;
  endtask

  // one request; on a miss, supply fill word fdata
  task automatic access(input logic [31:0] addr, input logic [31:0] fdata, input string req);
    int unsigned s = (addr >> 2) & 3;
    int unsigned t = addr >> 4;
    int hw = -1;
    int vw;
    for (int w = 0; w < 2; w++) if (m_valid[w][s] && m_tag[w][s] == t) hw = w;
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    if (hw >= 0) begin
      check_outs(req, 1'b1, 1'b1, 1'b0, 1'b0);
      check(rsp_data == m_data[hw][s], {req, " hit data"}, rsp_data, m_data[hw][s]);
      m_recent[s] = (hw == 0);
    end else begin
      check_outs(req, 1'b0, 1'b0, 1'b1, 1'b1);
      if (!m_valid[0][s])      vw = 0;
      else if (!m_valid[1][s]) vw = 1;
      else                     vw = m_recent[s] ? 1 : 0;
      @(negedge clk);
      check_outs({req, " wait"}, 1'b0, 1'b0, 1'b0, 1'b1);
      fill_valid = 1'b1; fill_data = fdata;
      @(negedge clk);
      fill_valid = 1'b0;
      check_outs({req, " fill"}, 1'b1, 1'b0, 1'b0, 1'b0);
      check(rsp_data == fdata, {req, " fill data"}, rsp_data, fdata);
      m_valid[vw][s] = 1'b1; m_tag[vw][s] = t; m_data[vw][s] = fdata;
      m_recent[s] = (vw == 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
    req_addr = '0; fill_data = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check_outs("R2 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_outs("R2 idle", 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: two addresses of set 1 co-reside
    access(32'h4,  32'hA000_0004, "R10 first");
    access(32'h24, 32'hA000_0024, "R10 second");
    for (int i = 0; i < 4; i++) begin
      access(32'h4,  32'h0, "R10 alt 0x4");
      access(32'h24, 32'h0, "R10 alt 0x24");
    end
    // R11: offset bits ignored
    access(32'h7, 32'h0, "R11 offset");
    // R1: other sets and tags
    access(32'h0,        32'h1111_0000, "R1 set0");
    access(32'h8,        32'h2222_0008, "R1 set2");
    access(32'hFFFF_FFFC, 32'h3333_FFFC, "R1 set3 high tag");
    access(32'h14,       32'h4444_0014, "R1 set1 other tag");
    access(32'h0,        32'h0, "R4 set0 hit");
    access(32'hFFFF_FFFC, 32'h0, "R4 set3 hit");
    // R7/R8: steer recency then evict
    access(32'h24, 32'h0,          "R8 touch");
    access(32'h64, 32'h5555_0064,  "R7 evict lru");
    access(32'h24, 32'h0,          "R7 survivor");
    access(32'h4,  32'h6666_0004,  "R7 evicted refill");
    access(32'h64, 32'h7777_0064,  "R8 lru order");

    // R6: request while busy is ignored
    req_valid = 1'b1; req_addr = 32'h100;
    @(negedge clk);
    check_outs("R6 miss", 1'b0, 1'b0, 1'b1, 1'b1);
    req_addr = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    check_outs("R6 ignored req", 1'b0, 1'b0, 1'b0, 1'b1);
    fill_valid = 1'b1; fill_data = 32'h8888_0100;
    @(negedge clk);
    fill_valid = 1'b0;
    check_outs("R6 fill", 1'b1, 1'b0, 1'b0, 1'b0);
    check(rsp_data == 32'h8888_0100, "R6 fill data", rsp_data, 32'h8888_0100);
    // model: set0 had 0x0 in way0 (recent), so way1 takes 0x100
    m_valid[1][0] = 1'b1; m_tag[1][0] = 32'h10; m_data[1][0] = 32'h8888_0100; m_recent[0] = 1'b0;
    access(32'h100, 32'h0, "R6 filled entry hits");
    access(32'h0,   32'h0, "R5 single hit set0");

    // R9: flush during a pending miss
    req_valid = 1'b1; req_addr = 32'h208;
    @(negedge clk);
    req_valid = 1'b0;
    check_outs("R9 miss", 1'b0, 1'b0, 1'b1, 1'b1);
    flush = 1'b1; req_valid = 1'b1; req_addr = 32'h0;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    check_outs("R9 flush drops", 1'b0, 1'b0, 1'b0, 1'b0);
    model_clear();
    @(negedge clk);
    check_outs("R9 quiet", 1'b0, 1'b0, 1'b0, 1'b0);
    access(32'h0,  32'h9999_0000, "R9 after flush miss");
    access(32'h24, 32'hAAAA_0024, "R9 after flush miss set1");
    access(32'h4,  32'hBBBB_0004, "R7 invalid way first");
    access(32'h24, 32'h0,         "R7 both kept");
    access(32'h4,  32'h0,         "R7 both kept b");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule